// File: doc/BRIEF.md
# Complementary Gate Driver Stage with Dead Band and Trip

This block drives one half-bridge leg. It takes a single raw PWM command and produces two gate commands: one for the high-side switch and one for the low-side switch. The two commands are never active together. Each handover from one switch to the other passes through a both-off gap of programmable length. The gap before the high side turns on and the gap before the low side turns on come from two separate settings. This lets the two edges suit switches whose turn-on and turn-off times differ.

Two protection paths act on the leg:

- **Current-limit trip.** A trip from an overcurrent comparator ends the present high-side pulse at once. The high side stays off for the rest of that PWM period and is released by the next period-start strobe.
- **Hard fault.** A hard fault input turns both gates off in the same cycle and sets a latched fault flag. The flag clears only on an explicit clear command, and that command has no effect while the fault input is still high. After a clear, and after reset, the leg stays fully off until a period-start strobe arrives. It then brings up the low side first, after the falling-edge dead time.

A state machine holds the leg in one of six states:

| State | Meaning |
|---|---|
| `ST_SAFE` | Both gates off; waiting for a period strobe |
| `ST_RESUME` | Both gates off; timing the low-side gap before the first low-side turn-on |
| `ST_LO_ON` | Low side conducting |
| `ST_HI_DLY` | Both gates off; timing the rising-edge gap before the high side turns on |
| `ST_HI_ON` | High side conducting |
| `ST_LO_DLY` | Both gates off; timing the falling-edge gap before the low side turns on |

The transitions are:

- **Block (any state → `ST_SAFE`).** Taken when the fault input or the latched fault is set.
- **Strobe start (`ST_SAFE` → `ST_RESUME`).** Taken on a period strobe with no fault present.
- **Resume done (`ST_RESUME` → `ST_LO_ON`).** Taken when the gap count expires.
- **Command rise (`ST_LO_ON` → `ST_HI_DLY`).**
- **Rise done (`ST_HI_DLY` → `ST_HI_ON`).**
- **Abort (`ST_HI_DLY` → `ST_LO_DLY`).** Taken when the command falls before the gap expires.
- **Command fall or trip (`ST_HI_ON` → `ST_LO_DLY`).**
- **Fall done (`ST_LO_DLY` → `ST_LO_ON`).**

Top module: `dtg_leg`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1. Every turn-on of either gate is preceded by at least one cycle in which both are 0.
- R2: Let Er = max(`dead_rise`,1) clock cycles. When the command rises while the low side conducts, the low side turns off at the next edge. The high side turns on Er cycles later. A raw pulse of P cycles with P > Er gives a high-side pulse of P − Er cycles.
- R3: Let Ef = max(`dead_fall`,1) clock cycles, set independently of `dead_rise`. When the command falls, the high side turns off at the next edge. The low side turns on Ef cycles later. The low side is therefore off for P + Ef cycles around a raw pulse of P cycles.
- R4: A raw pulse of P ≤ Er cycles produces no high-side pulse. The low side still stays off for P + Ef cycles.
- R5: While `ilim_trip` is 1, `gate_hi` is 0 in that same cycle. If `ilim_trip` is 1 while `pwm_raw` is 1, the high side stays off until the next `period_strobe`, even with `pwm_raw` still 1. The low side takes over after Ef cycles.
- R6: A `period_strobe` releases the truncation, so the next raw pulse gets its full high-side width per R2.
- R7: While `hard_fault` is 1, both gates are 0 in that same cycle. `fault_latched` reads 1 from the next cycle.
- R8: `fault_latched` stays 1 until `fault_clr` is 1 in a cycle where `hard_fault` is 0. A clear while `hard_fault` is 1 is ignored. Both gates stay 0 while `fault_latched` is 1.
- R9: After a clear, both gates stay 0 until a `period_strobe`, whatever `pwm_raw` does. On the strobe edge the leg starts counting. The low side turns on Ef cycles after that edge, before any high-side turn-on. With the command already high, the high side then follows 1 + Er cycles after the low side turned on.
- R10: After reset, both gates and `fault_latched` are 0. The leg then behaves as after a clear (R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_raw | input | 1 | Raw PWM command, 1 asks for the high side |
| period_strobe | input | 1 | One-cycle pulse at the start of each PWM period |
| dead_rise | input | DT_W | Gap in cycles before the high side turns on |
| dead_fall | input | DT_W | Gap in cycles before the low side turns on |
| ilim_trip | input | 1 | Cycle-by-cycle current-limit trip |
| hard_fault | input | 1 | Hard fault, forces both gates off |
| fault_clr | input | 1 | Request to clear the latched fault |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| fault_latched | output | 1 | Latched hard-fault flag |

## Verification
The bench builds the leg with `DT_W` = 3, so both dead-time settings fit in three bits. It sweeps every pairing of rising and falling settings from 0 to 4 against raw pulse widths from 1 to 7 cycles. This covers the zero-setting clamp, pulses shorter than, equal to and longer than the rising gap, and the independence of the two edges. The expected high-side width and low-side off time are computed arithmetically for each case. Separate sequences cover a mid-pulse trip and its release by the period strobe, a hard fault with a clear attempted under an active fault, and low-side-first resumption after reset and after a clear.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        ST_SAFE,
        ST_RESUME,
        ST_LO_ON,
        ST_HI_DLY,
        ST_HI_ON,
        ST_LO_DLY
    } leg_state_t;

endpackage

// File: rtl/dtg_trip_mask.sv
module dtg_trip_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_raw,
    input  logic ilim_trip,
    input  logic period_strobe,
    output logic cmd
);

    logic trunc_q;

    // Truncation latch: a trip while the raw command is high keeps the
    // command low until the next period start; a new trip wins over a strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trunc_q <= 1'b0;
        end else if (ilim_trip && pwm_raw) begin
            trunc_q <= 1'b1;
        end else if (period_strobe) begin
            trunc_q <= 1'b0;
        end
    end

    assign cmd = pwm_raw & ~trunc_q & ~ilim_trip;

endmodule

// File: rtl/dtg_fault_hold.sv
module dtg_fault_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hard_fault,
    input  logic fault_clr,
    output logic fault_q,
    output logic block
);

    // The fault input has priority, so a clear cannot act while it is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (hard_fault) begin
            fault_q <= 1'b1;
        end else if (fault_clr) begin
            fault_q <= 1'b0;
        end
    end

    assign block = hard_fault | fault_q;

endmodule

// File: rtl/dtg_band_fsm.sv
module dtg_band_fsm
    import dtg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd,
    input  logic            block,
    input  logic            period_strobe,
    input  logic [DT_W-1:0] dead_rise,
    input  logic [DT_W-1:0] dead_fall,
    output logic            hi_on,
    output logic            lo_on
);

    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    leg_state_t      state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            last;

    // A count of zero or one ends the gap after one cycle.
    assign last = (cnt_q <= CNT_ONE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (block) begin
            state_d = ST_SAFE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_SAFE: begin
                    if (period_strobe) begin
                        state_d = ST_RESUME;
                        cnt_d   = dead_fall;
                    end
                end
                ST_RESUME: begin
                    if (last) state_d = ST_LO_ON;
                    else      cnt_d   = cnt_q - CNT_ONE;
                end
                ST_LO_ON: begin
                    if (cmd) begin
                        state_d = ST_HI_DLY;
                        cnt_d   = dead_rise;
                    end
                end
                ST_HI_DLY: begin
                    if (!cmd) begin
                        state_d = ST_LO_DLY;
                        cnt_d   = dead_fall;
                    end else if (last) begin
                        state_d = ST_HI_ON;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                ST_HI_ON: begin
                    if (!cmd) begin
                        state_d = ST_LO_DLY;
                        cnt_d   = dead_fall;
                    end
                end
                ST_LO_DLY: begin
                    if (last) state_d = ST_LO_ON;
                    else      cnt_d   = cnt_q - CNT_ONE;
                end
                default: begin
                    state_d = ST_SAFE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAFE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        hi_on = 1'b0;
        lo_on = 1'b0;
        unique case (state_q)
            ST_HI_ON: hi_on = 1'b1;
            ST_LO_ON: lo_on = 1'b1;
            default: begin
                hi_on = 1'b0;
                lo_on = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dtg_leg.sv
module dtg_leg #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_raw,
    input  logic            period_strobe,
    input  logic [DT_W-1:0] dead_rise,
    input  logic [DT_W-1:0] dead_fall,
    input  logic            ilim_trip,
    input  logic            hard_fault,
    input  logic            fault_clr,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            fault_latched
);

    logic cmd;
    logic block;
    logic hi_on;
    logic lo_on;

    dtg_trip_mask u_trip (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_raw       (pwm_raw),
        .ilim_trip     (ilim_trip),
        .period_strobe (period_strobe),
        .cmd           (cmd)
    );

    dtg_fault_hold u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .hard_fault (hard_fault),
        .fault_clr  (fault_clr),
        .fault_q    (fault_latched),
        .block      (block)
    );

    dtg_band_fsm #(.DT_W(DT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .block         (block),
        .period_strobe (period_strobe),
        .dead_rise     (dead_rise),
        .dead_fall     (dead_fall),
        .hi_on         (hi_on),
        .lo_on         (lo_on)
    );

    // Fast kill paths act in the same cycle as the trip or fault input.
    assign gate_hi = hi_on & ~hard_fault & ~ilim_trip;
    assign gate_lo = lo_on & ~hard_fault;

endmodule

// File: rtl/dtg_leg_chk.sv
module dtg_leg_chk (
    input logic clk,
    input logic rst_n,
    input logic ilim_trip,
    input logic hard_fault,
    input logic fault_clr,
    input logic gate_hi,
    input logic gate_lo,
    input logic fault_latched
);

    assert_never_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    assert_hi_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(gate_lo));

    assert_lo_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> !$past(gate_hi));

    assert_trip_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_trip |=> !gate_hi);

    assert_fault_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hard_fault |=> fault_latched);

    assert_latch_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && !fault_clr) |=> fault_latched);

    assert_latched_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> (!gate_hi && !gate_lo));

    assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched) |-> (!gate_hi && !gate_lo));

endmodule

bind dtg_leg dtg_leg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ilim_trip     (ilim_trip),
    .hard_fault    (hard_fault),
    .fault_clr     (fault_clr),
    .gate_hi       (gate_hi),
    .gate_lo       (gate_lo),
    .fault_latched (fault_latched)
);

// File: tb/sim_dtg_leg.sv
module sim_dtg_leg;

    localparam int DT_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_raw = 1'b0;
    logic            period_strobe = 1'b0;
    logic [DT_W-1:0] dead_rise = '0;
    logic [DT_W-1:0] dead_fall = '0;
    logic            ilim_trip = 1'b0;
    logic            hard_fault = 1'b0;
    logic            fault_clr = 1'b0;
    logic            gate_hi;
    logic            gate_lo;
    logic            fault_latched;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dtg_leg #(.DT_W(DT_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_raw       (pwm_raw),
        .period_strobe (period_strobe),
        .dead_rise     (dead_rise),
        .dead_fall     (dead_fall),
        .ilim_trip     (ilim_trip),
        .hard_fault    (hard_fault),
        .fault_clr     (fault_clr),
        .gate_hi       (gate_hi),
        .gate_lo       (gate_lo),
        .fault_latched (fault_latched)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int d);
        return (d < 1) ? 1 : d;
    endfunction

    // One raw pulse of p cycles from steady low-side conduction.
    task automatic run_pulse(input int dr, input int df, input int p, input string tag);
        int hi_n = 0;
        int lo_off = 0;
        int both = 0;
        int exp_hi;
        dead_rise = DT_W'(dr);
        dead_fall = DT_W'(df);
        pwm_raw = 1'b1;
        for (int k = 1; k <= p + 8; k++) begin
            @(negedge clk);
            if (gate_hi) hi_n++;
            if (!gate_lo) lo_off++;
            if (gate_hi && gate_lo) both++;
            if (k == p) pwm_raw = 1'b0;
        end
        exp_hi = (p > eff(dr)) ? p - eff(dr) : 0;
        check({tag, " high width"}, hi_n, exp_hi);
        check({tag, " R3 low off span"}, lo_off, p + eff(df));
        check({tag, " R1 overlap"}, both, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        int first_lo;
        int first_hi;

        // R10: reset state, and quiet until a period strobe
        repeat (3) @(negedge clk);
        check("R10 gate_hi at reset", int'(gate_hi), 0);
        check("R10 gate_lo at reset", int'(gate_lo), 0);
        check("R10 fault flag at reset", int'(fault_latched), 0);
        rst_n = 1'b1;
        dead_rise = 3'd2;
        dead_fall = 3'd2;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (gate_hi || gate_lo) cnt++;
            pwm_raw = (k % 3 == 0);
        end
        check("R10 no output before strobe", cnt, 0);
        pwm_raw = 1'b0;
        period_strobe = 1'b1;
        cnt = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            period_strobe = 1'b0;
            if (!gate_lo) cnt++;
        end
        check("R9 low side after strobe", cnt, 2);

        // R2 R3 R4: sweep of both dead settings against pulse widths
        for (int dr = 0; dr <= 4; dr++) begin
            for (int df = 0; df <= 4; df++) begin
                for (int p = 1; p <= 7; p++) begin
                    run_pulse(dr, df, p, (p > eff(dr)) ? "R2" : "R4");
                end
            end
        end

        // R5: trip during the on-time, then R6 release by strobe
        dead_rise = 3'd1;
        dead_fall = 3'd1;
        period_strobe = 1'b1;
        @(negedge clk);
        period_strobe = 1'b0;
        pwm_raw = 1'b1;
        cnt = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (gate_hi) cnt++;
            if (k == 3) begin
                ilim_trip = 1'b1;
                #1;
                check("R5 same-cycle kill", int'(gate_hi), 0);
            end
            if (k == 4) ilim_trip = 1'b0;
        end
        check("R5 truncated width", cnt, 2);
        check("R5 low side holds", int'(gate_lo), 1);
        pwm_raw = 1'b0;
        @(negedge clk);
        check("R5 still truncated", int'(gate_hi), 0);
        period_strobe = 1'b1;
        @(negedge clk);
        period_strobe = 1'b0;
        repeat (3) @(negedge clk);
        run_pulse(1, 1, 6, "R6");

        // R7 R8: hard fault during high-side conduction
        pwm_raw = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 high on before fault", int'(gate_hi), 1);
        hard_fault = 1'b1;
        #1;
        check("R7 gates off same cycle", int'(gate_hi | gate_lo), 0);
        @(negedge clk);
        check("R7 fault latched", int'(fault_latched), 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check("R8 clear ignored under fault", int'(fault_latched), 1);
        hard_fault = 1'b0;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (gate_hi || gate_lo) cnt++;
            pwm_raw = (k % 2 == 0);
            period_strobe = (k == 3);
        end
        period_strobe = 1'b0;
        check("R8 gates off while latched", cnt, 0);
        check("R8 still latched", int'(fault_latched), 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check("R8 flag cleared", int'(fault_latched), 0);

        // R9: quiet until strobe, then low side first
        pwm_raw = 1'b1;
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (gate_hi || gate_lo) cnt++;
        end
        check("R9 quiet after clear", cnt, 0);
        period_strobe = 1'b1;
        first_lo = 0;
        first_hi = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            period_strobe = 1'b0;
            if (gate_lo && first_lo == 0) first_lo = k;
            if (gate_hi && first_hi == 0) first_hi = k;
        end
        check("R9 low side first", first_lo, 2);
        check("R9 high side follows", first_hi, 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule